// File: doc/BRIEF.md
# Port-Mapped Watchdog Timer

This block watches a processor's I/O read cycles and acts as a watchdog. It needs no data path. A read of one fixed port arms the timer. A later read of the same port restarts the count. A read of a second fixed port turns the timer off. Each read is recognised from the read strobe and a full 16-bit address.

Two strap inputs set the behaviour at board level. A 3-bit strap picks one of six timeout lengths, from 1 to 220 seconds. A 2-bit strap picks what happens on expiry: a non-maskable interrupt pulse, a system reset pulse, or nothing, in which case the watchdog stays off. An internal divider turns the clock into one-second ticks, and the timer counts whole seconds. If software does not restart the count in time, the chosen pulse is issued and the watchdog falls back to the disarmed state.

Top module: `port_watchdog`

## Requirements
- R1: After reset the watchdog is disarmed, does not count, and drives both pulse outputs low until it is armed.
- R2: A read of address 0x0443 while disarmed arms the watchdog. If nothing else happens, the pulse output rises exactly period × CLKS_PER_SEC clock edges after the edge that captured the read.
- R3: A read of 0x0443 while armed is a refresh. The count restarts from zero, so the pulse rises period × CLKS_PER_SEC edges after the refresh edge.
- R4: A read of address 0x0045 disarms the watchdog, and no pulse follows. A later arming read starts a fresh full period.
- R5: The period strap, read as bits [2:1:0], selects the timeout in seconds: 111→1, 011→2, 101→10, 001→20, 110→110, 010→220.
- R6: The unlisted period strap codes 000 and 100 select the 1-second period.
- R7: The action strap selects the expiry action: 01 gives an NMI pulse and 10 gives a reset pulse. Codes 00 and 11 disable the watchdog, so arming reads are ignored and no pulse is ever issued.
- R8: Each expiry pulse lasts exactly PULSE_CYCLES clock cycles, and the two outputs are never high together.
- R9: An access counts only when the whole 16-bit address matches and the read strobe is high with the write strobe low. Writes, and reads of other addresses, change nothing.
- R10: A read strobe held high for several cycles counts as one access, taken at its first cycle.
- R11: After an expiry the watchdog is disarmed and issues no further pulse until it is armed again.
- R12: A refresh captured on the same edge at which the period would expire takes priority. No pulse is issued and a new full period begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_rd | input | 1 | I/O read strobe |
| io_wr | input | 1 | I/O write strobe |
| io_addr | input | 16 | I/O port address |
| period_strap | input | 3 | Timeout period select |
| action_strap | input | 2 | Expiry action select (01 NMI, 10 reset) |
| sys_rst_pulse | output | 1 | System reset pulse |
| nmi_pulse | output | 1 | Non-maskable interrupt pulse |

## Verification
Each of the eight period strap codes is armed once, so every decoded period and both fallback codes are measured to the exact clock edge. The access patterns each separate one pair of alternatives:
- a bare arm against an arm followed by a refresh, which shows whether the count restarts;
- an arm followed by a disarm read, which shows whether counting stops;
- writes, wrong-address reads and reads with both strobes high, which show whether the decode is strict;
- one long read strobe, which shows edge detection against level detection;
- a refresh placed exactly on the expiry edge, which shows which of the two wins.

Both enabled action codes and both disabled action codes are run, so the pulse kind, its width and the suppression of pulses are each observed at the outputs.

// File: rtl/wdg_pkg.sv
// Package: shared constants, action type and strap decoders for the
// port-mapped watchdog. Assumes straps are static or slowly changing.
package wdg_pkg;

    localparam int SEC_W = 8;   // wide enough for the longest period (220 s)

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_NMI  = 2'd1,
        ACT_RST  = 2'd2
    } wdg_act_e;

    // Action strap: bit0 = NMI link, bit1 = reset link; both or neither = off
    function automatic wdg_act_e decode_action(input logic [1:0] strap);
        case (strap)
            2'b01:   return ACT_NMI;
            2'b10:   return ACT_RST;
            default: return ACT_NONE;
        endcase
    endfunction

    // Period strap to whole seconds; unlisted codes fall back to 1 s
    function automatic logic [SEC_W-1:0] period_secs(input logic [2:0] code);
        case (code)
            3'b111:  return SEC_W'(1);
            3'b011:  return SEC_W'(2);
            3'b101:  return SEC_W'(10);
            3'b001:  return SEC_W'(20);
            3'b110:  return SEC_W'(110);
            3'b010:  return SEC_W'(220);
            default: return SEC_W'(1);
        endcase
    endfunction

endpackage

// File: rtl/wdg_port_decode.sv
// Module: wdg_port_decode
// Turns I/O read cycles into single-cycle hit strobes for the arm/refresh
// port and the disarm port. Only the first cycle of a read strobe counts,
// the full address must match, and a cycle with the write strobe high is
// never treated as a read. Outputs are combinational from the inputs.
module wdg_port_decode #(
    parameter int          ADDR_W      = 16,
    parameter logic [15:0] ARM_ADDR    = 16'h0443,
    parameter logic [15:0] DISARM_ADDR = 16'h0045
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    output logic              arm_hit,
    output logic              disarm_hit
);

    logic rd_q;
    logic rd_start;

    // Purpose: remember last cycle's read strobe for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= 1'b0;
        else        rd_q <= io_rd;
    end

    // Purpose: qualify a new read and match it against the two ports
    always_comb begin
        rd_start   = io_rd && !io_wr && !rd_q;
        arm_hit    = rd_start && (io_addr == ADDR_W'(ARM_ADDR));
        disarm_hit = rd_start && (io_addr == ADDR_W'(DISARM_ADDR));
    end

    // R10: a held strobe never yields two hits in a row
    p_held_read_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
        arm_hit |=> !arm_hit);

endmodule

// File: rtl/wdg_tick_div.sv
// Module: wdg_tick_div
// Divides the clock into a one-second tick while run is high. A clear
// restarts the division from zero so a period is measured from the clear
// edge. Assumes CLKS_PER_SEC >= 2.
module wdg_tick_div #(
    parameter int CLKS_PER_SEC = 100_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clear,
    output logic tick
);

    localparam int CW = (CLKS_PER_SEC > 2) ? $clog2(CLKS_PER_SEC) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLKS_PER_SEC - 1);

    logic [CW-1:0] div_cnt;

    // Purpose: count clocks within the current second
    always_ff @(posedge clk) begin
        if (!rst_n || clear || !run) div_cnt <= '0;
        else if (div_cnt == LAST)    div_cnt <= '0;
        else                         div_cnt <= div_cnt + 1'b1;
    end

    // Purpose: flag the last clock of each second
    always_comb tick = run && !clear && (div_cnt == LAST);

    // R2: ticks are spaced by at least two clocks
    p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/wdg_pulse_gen.sv
// Module: wdg_pulse_gen
// Issues one fixed-length pulse on the output chosen by kind when fire is
// seen. Assumes fire never arrives while a pulse is still in progress
// (a period always exceeds PULSE_CYCLES).
module wdg_pulse_gen
    import wdg_pkg::*;
#(
    parameter int PULSE_CYCLES = 16
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     fire,
    input  wdg_act_e kind,
    output logic     rst_out,
    output logic     nmi_out
);

    localparam int PW_W = $clog2(PULSE_CYCLES + 1);

    logic [PW_W-1:0] left;
    wdg_act_e        kind_q;

    // Purpose: load and run down the pulse length counter, latch the kind
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left   <= '0;
            kind_q <= ACT_NONE;
        end else if (fire) begin
            left   <= PW_W'(PULSE_CYCLES);
            kind_q <= kind;
        end else if (left != '0) begin
            left   <= left - 1'b1;
        end
    end

    // Purpose: steer the active pulse to its output
    always_comb begin
        rst_out = (left != '0) && (kind_q == ACT_RST);
        nmi_out = (left != '0) && (kind_q == ACT_NMI);
    end

    // R8: the two outputs are never high together
    p_one_output_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rst_out, nmi_out}));

    // R8: a new expiry never cuts an earlier pulse short
    p_fire_when_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> (left == '0));

endmodule

// File: rtl/port_watchdog.sv
// Module: port_watchdog (top)
// Watchdog armed, refreshed and disarmed by I/O reads of two fixed ports.
// Counts whole seconds while armed and issues an NMI or reset pulse when
// the strap-selected period elapses without a refresh. Assumes the
// straps are static during operation, and resets synchronously, active low.
module port_watchdog
    import wdg_pkg::*;
#(
    parameter int          CLKS_PER_SEC = 100_000_000,
    parameter int          PULSE_CYCLES = 16,
    parameter logic [15:0] ARM_ADDR     = 16'h0443,
    parameter logic [15:0] DISARM_ADDR  = 16'h0045
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        io_rd,
    input  logic        io_wr,
    input  logic [15:0] io_addr,
    input  logic [2:0]  period_strap,
    input  logic [1:0]  action_strap,
    output logic        sys_rst_pulse,
    output logic        nmi_pulse
);

    logic             arm_hit, disarm_hit;
    logic             armed;
    logic [SEC_W-1:0] sec_cnt;
    logic [SEC_W-1:0] limit;
    logic [SEC_W:0]   sec_next;
    wdg_act_e         act;
    logic             restart, tick, expire;

    wdg_port_decode #(
        .ADDR_W      (16),
        .ARM_ADDR    (ARM_ADDR),
        .DISARM_ADDR (DISARM_ADDR)
    ) u_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .io_rd      (io_rd),
        .io_wr      (io_wr),
        .io_addr    (io_addr),
        .arm_hit    (arm_hit),
        .disarm_hit (disarm_hit)
    );

    // Purpose: decode straps and work out restart and expiry for this cycle
    always_comb begin
        act      = decode_action(action_strap);
        limit    = period_secs(period_strap);
        restart  = arm_hit && (act != ACT_NONE);
        sec_next = {1'b0, sec_cnt} + 1'b1;
        expire   = armed && tick && !restart && !disarm_hit
                   && (act != ACT_NONE) && (sec_next >= {1'b0, limit});
    end

    wdg_tick_div #(
        .CLKS_PER_SEC (CLKS_PER_SEC)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (armed),
        .clear (restart),
        .tick  (tick)
    );

    // Purpose: armed state and whole-second count
    always_ff @(posedge clk) begin
        if (!rst_n || act == ACT_NONE) begin
            armed   <= 1'b0;
            sec_cnt <= '0;
        end else if (restart) begin
            armed   <= 1'b1;
            sec_cnt <= '0;
        end else if (disarm_hit || expire) begin
            armed   <= 1'b0;
            sec_cnt <= '0;
        end else if (armed && tick) begin
            sec_cnt <= sec_next[SEC_W-1:0];
        end
    end

    wdg_pulse_gen #(
        .PULSE_CYCLES (PULSE_CYCLES)
    ) u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (expire),
        .kind    (act),
        .rst_out (sys_rst_pulse),
        .nmi_out (nmi_pulse)
    );

    // R1: no second tick is produced while disarmed
    p_idle_no_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> !tick);

    // R2: an accepted arming read leaves the watchdog armed
    p_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_hit && act != ACT_NONE) |=> armed);

    // R4: a disarm read leaves the watchdog disarmed
    p_disarm_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (disarm_hit && !arm_hit) |=> !armed);

    // R7: a disabled action strap keeps the watchdog disarmed
    p_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_NONE) |=> !armed);

    // R11: expiry returns to the disarmed state
    p_expire_disarms_r11: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !armed);

endmodule

// File: tb/tb_port_watchdog.sv
// Scoreboard bench: driver tasks push expected pulses (kind, edge number),
// a monitor on the falling clock edge pops and compares them.
module tb_port_watchdog;

    localparam int CPS = 8;
    localparam int PW  = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic [15:0] io_addr = 16'h0000;
    logic [2:0]  period_strap = 3'b111;
    logic [1:0]  action_strap = 2'b01;
    logic        sys_rst_pulse, nmi_pulse;

    port_watchdog #(
        .CLKS_PER_SEC (CPS),
        .PULSE_CYCLES (PW)
    ) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .io_rd         (io_rd),
        .io_wr         (io_wr),
        .io_addr       (io_addr),
        .period_strap  (period_strap),
        .action_strap  (action_strap),
        .sys_rst_pulse (sys_rst_pulse),
        .nmi_pulse     (nmi_pulse)
    );

    always #2 clk = ~clk;   // 250 MHz

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int    kind;   // 1 = NMI, 2 = reset
        int    at;     // edge number at which the output rises
        string req;
    } exp_t;

    exp_t q[$];
    int   n_cmp = 0;
    int   n_bad = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Expected period in seconds for each strap code
    function automatic int exp_period(input int code);
        case (code)
            7: return 1;
            3: return 2;
            5: return 10;
            1: return 20;
            6: return 110;
            2: return 220;
            default: return 1;
        endcase
    endfunction

    // Driver: one read access; returns the edge that captures it
    task automatic do_read(input logic [15:0] a, input int hold, input bit wr,
                           output int edge_no);
        @(negedge clk);
        io_addr = a;
        io_rd   = 1'b1;
        io_wr   = wr;
        edge_no = cyc + 1;
        repeat (hold) @(negedge clk);
        io_rd = 1'b0;
        io_wr = 1'b0;
    endtask

    task automatic do_write(input logic [15:0] a);
        @(negedge clk);
        io_addr = a;
        io_wr   = 1'b1;
        @(negedge clk);
        io_wr   = 1'b0;
    endtask

    task automatic expect_evt(input int kind, input int at, input string req);
        exp_t e;
        e.kind = kind;
        e.at   = at;
        e.req  = req;
        q.push_back(e);
    endtask

    task automatic drain(input int n, input string req);
        repeat (n) @(negedge clk);
        check(q.size() == 0, req, "pending expected pulses", q.size(), 0);
    endtask

    // Monitor: compare pulse rises against the scoreboard, measure widths
    logic prev_n = 1'b0, prev_r = 1'b0;
    int   w_n = 0, w_r = 0;

    task automatic on_rise(input int kind);
        exp_t e;
        if (q.size() == 0) begin
            check(1'b0, "R4/R7/R9/R11", "unexpected pulse kind", kind, 0);
        end else begin
            e = q.pop_front();
            check(kind == e.kind, e.req, "pulse kind", kind, e.kind);
            check(cyc == e.at, e.req, "pulse edge", cyc, e.at);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (nmi_pulse && sys_rst_pulse)
                check(1'b0, "R8", "both outputs high", 1, 0);
            if (nmi_pulse && !prev_n) on_rise(1);
            if (sys_rst_pulse && !prev_r) on_rise(2);
            if (nmi_pulse) w_n++;
            if (sys_rst_pulse) w_r++;
            if (!nmi_pulse && prev_n) begin
                check(w_n == PW, "R8", "NMI width", w_n, PW);
                w_n = 0;
            end
            if (!sys_rst_pulse && prev_r) begin
                check(w_r == PW, "R8", "reset width", w_r, PW);
                w_r = 0;
            end
        end
        prev_n = nmi_pulse;
        prev_r = sys_rst_pulse;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int e1, e2;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: quiet after reset, no counting without an arm
        @(negedge clk);
        check(nmi_pulse == 1'b0, "R1", "nmi after reset", nmi_pulse, 0);
        check(sys_rst_pulse == 1'b0, "R1", "reset after reset", sys_rst_pulse, 0);
        drain(40, "R1");

        // R2: arm with NMI, 1 s
        action_strap = 2'b01; period_strap = 3'b111;
        do_read(16'h0443, 1, 1'b0, e1);
        expect_evt(1, e1 + CPS, "R2");
        drain(3 * CPS, "R2");
        // R11: no further pulse without re-arm
        drain(5 * CPS, "R11");

        // R7: reset action, 2 s
        action_strap = 2'b10; period_strap = 3'b011;
        do_read(16'h0443, 1, 1'b0, e1);
        expect_evt(2, e1 + 2 * CPS, "R7");
        drain(4 * CPS, "R7");

        // R3: refresh restarts the count
        action_strap = 2'b01;
        do_read(16'h0443, 1, 1'b0, e1);
        repeat (9) @(negedge clk);
        do_read(16'h0443, 1, 1'b0, e2);
        expect_evt(1, e2 + 2 * CPS, "R3");
        drain(5 * CPS, "R3");

        // R4: disarm stops counting, re-arm gives a full period
        do_read(16'h0443, 1, 1'b0, e1);
        repeat (5) @(negedge clk);
        do_read(16'h0045, 1, 1'b0, e2);
        drain(6 * CPS, "R4");
        do_read(16'h0443, 1, 1'b0, e1);
        expect_evt(1, e1 + 2 * CPS, "R4");
        drain(4 * CPS, "R4");

        // R5 / R6: every period strap code
        for (int c = 0; c < 8; c++) begin
            period_strap = 3'(c);
            do_read(16'h0443, 1, 1'b0, e1);
            expect_evt(1, e1 + exp_period(c) * CPS,
                       (c == 0 || c == 4) ? "R6" : "R5");
            drain(exp_period(c) * CPS + 20, (c == 0 || c == 4) ? "R6" : "R5");
        end

        // R9: writes, other addresses and write-qualified reads are ignored
        period_strap = 3'b111;
        do_write(16'h0443);
        do_read(16'h1443, 1, 1'b0, e1);
        do_read(16'h0443, 1, 1'b1, e1);
        do_read(16'h0043, 1, 1'b0, e1);
        drain(5 * CPS, "R9");
        do_read(16'h0443, 1, 1'b0, e1);
        expect_evt(1, e1 + CPS, "R9");
        drain(3 * CPS, "R9");

        // R10: a long strobe counts once, at its first cycle
        do_read(16'h0443, 5, 1'b0, e1);
        expect_evt(1, e1 + CPS, "R10");
        drain(3 * CPS, "R10");

        // R7: disabled codes ignore arming, also mid count
        action_strap = 2'b00;
        do_read(16'h0443, 1, 1'b0, e1);
        drain(5 * CPS, "R7");
        action_strap = 2'b11;
        do_read(16'h0443, 1, 1'b0, e1);
        drain(5 * CPS, "R7");
        action_strap = 2'b01;
        do_read(16'h0443, 1, 1'b0, e1);
        repeat (3) @(negedge clk);
        action_strap = 2'b00;
        drain(5 * CPS, "R7");
        action_strap = 2'b01;

        // R12: refresh on the expiry edge wins
        period_strap = 3'b011;
        do_read(16'h0443, 1, 1'b0, e1);
        while (cyc < e1 + 2 * CPS - 2) @(negedge clk);
        do_read(16'h0443, 1, 1'b0, e2);
        check(e2 == e1 + 2 * CPS, "R12", "refresh edge placement", e2, e1 + 2 * CPS);
        expect_evt(1, e2 + 2 * CPS, "R12");
        drain(5 * CPS, "R12");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule